// File: doc/BRIEF.md
# ADC Command Queue Sequencer

The sequencer walks a table of conversion commands for two queues and hands each command to an abstract converter through a simple request/done handshake. Queue 1 always begins at table entry 0. Queue 2 begins at a boundary index that software programs. The same boundary also marks where queue 1 stops. Every table entry carries a channel field and a pause bit. The block fetches an entry, presents its index and channel to the converter, holds the request until the converter reports done, and then moves on.

Each queue can be idle, running or paused. A trigger pulse starts an idle queue or resumes a paused one. A trigger that arrives while the queue is running is recorded as an overrun. When both queues want the converter, queue 1 wins. A queue 2 pass that queue 1 interrupts is not restarted: it continues at its own saved index once queue 1 stops or pauses.

Software may rewrite the boundary while queue 1 is running. The new value is compared only when the next entry is fetched, and never against the conversion already in flight. Six status bits report completion, pause and overrun for each queue. Each bit is cleared by writing a one to it.

Top module: `cq_sequencer`

## Requirements
- R1: After reset, status is 0, conv_req is low, and both q1_busy and q2_busy are low.
- R2: For each fetched entry, the block raises conv_req with conv_idx set to that entry's index and conv_chan set to bits 6:0 of the entry. conv_req stays high with a stable index until a cycle with conv_done high, and drops in the next cycle.
- R3: Queue 1 fetches entries upward from index 0. When a fetched index equals the boundary, queue 1 ends without converting that entry and sets status bit 0. With a boundary of 0, queue 1 completes without any conversion.
- R4: A boundary write during a queue 1 conversion affects only later fetches. If the new value is the current index plus one, queue 1 ends after the current conversion. If the new value is equal to or below the current index, queue 1 does not end on that pass and runs through index 63.
- R5: Index 63 is the last table entry. After its conversion the active queue ends and sets its completion bit: status bit 0 for queue 1, bit 3 for queue 2.
- R6: Queue 2 starts at the boundary value held when its trigger arrives, and runs upward through index 63.
- R7: When an entry with bit 7 set finishes converting, the queue sets its pause bit (status bit 1 for queue 1, bit 4 for queue 2). The queue then stops issuing requests and stays busy. Its next trigger resumes it at the following entry and does not count as an overrun.
- R8: A trigger that arrives while its queue is running sets that queue's overrun bit (status bit 2 for queue 1, bit 5 for queue 2) and does not restart the queue.
- R9: Queue 1 has priority at every fetch. A queue 2 conversion already in flight is allowed to finish. Queue 2 then waits and resumes at its next saved index once queue 1 is idle or paused.
- R10: A cycle with clr_we high clears each status bit whose clr_mask bit is 1 and leaves the other bits unchanged. If hardware sets a bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_addr | input | 6 | Command table write index |
| tbl_wdata | input | 8 | Command entry: bit 7 pause, bits 6:0 channel |
| bnd_we | input | 1 | Boundary write enable |
| bnd_wdata | input | 6 | New boundary index |
| trig1 | input | 1 | Queue 1 trigger pulse |
| trig2 | input | 1 | Queue 2 trigger pulse |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 6 | Write-one-to-clear mask, same bit order as status |
| conv_done | input | 1 | Converter finished the requested conversion |
| conv_req | output | 1 | Conversion request, held until done |
| conv_idx | output | 6 | Table index of the requested conversion |
| conv_chan | output | 7 | Channel field of the requested entry |
| conv_queue | output | 1 | 0 when queue 1 owns the request, 1 when queue 2 owns it |
| q1_busy | output | 1 | Queue 1 running or paused |
| q2_busy | output | 1 | Queue 2 running or paused |
| status | output | 6 | Bit 0 cf1, 1 pf1, 2 tor1, 3 cf2, 4 pf2, 5 tor2 |

## Verification
A corrupted fetch pointer or boundary compare shows at the next rising edge of conv_req. That edge comes one cycle after the previous done, and it carries a skipped, repeated or out-of-range index, or queue 1 runs past its boundary. A queue state that is wrong, such as a lost pause or a false resume, shows within one fetch. The symptom is a request with the wrong conv_queue value, or busy not agreeing with the pause bit. A flag-merge error shows in status on the cycle after the event or clear.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

  localparam int STAT_W   = 6;
  localparam int ST_CF1   = 0;
  localparam int ST_PF1   = 1;
  localparam int ST_TOR1  = 2;
  localparam int ST_CF2   = 3;
  localparam int ST_PF2   = 4;
  localparam int ST_TOR2  = 5;

  typedef enum logic [1:0] {Q_IDLE, Q_RUN, Q_HOLD} qstate_e;
  typedef enum logic       {SQ_FETCH, SQ_WAIT} seq_e;

  // true when idx is the final table slot
  function automatic logic idx_is_last(input int idx, input int entries);
    return idx == entries - 1;
  endfunction

  // write-one-to-clear merge; hardware set dominates
  function automatic logic [STAT_W-1:0] w1c_merge(input logic [STAT_W-1:0] cur,
                                                  input logic [STAT_W-1:0] clr,
                                                  input logic [STAT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/cqs_cmd_table.sv
module cqs_cmd_table #(
  parameter int ENTRIES = 64,
  parameter int CMD_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CMD_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [CMD_W-1:0] rdata
);

  logic [CMD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cqs_queue_ctl.sv
module cqs_queue_ctl
  import cqs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             advance,
  input  logic             hold,
  input  logic             finish,
  output logic             active,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic             overrun
);

  qstate_e st;

  assign active  = (st == Q_RUN);
  assign busy    = (st != Q_IDLE);
  assign overrun = trig && (st == Q_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= Q_IDLE;
      ptr <= '0;
    end else begin
      if (finish)                     st <= Q_IDLE;
      else if (hold)                  st <= Q_HOLD;
      else if (trig && st == Q_HOLD)  st <= Q_RUN;
      else if (trig && st == Q_IDLE)  st <= Q_RUN;

      if (trig && st == Q_IDLE)       ptr <= start_idx;
      else if (advance)               ptr <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/cqs_flags.sv
module cqs_flags
  import cqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] flags
);

  logic [STAT_W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= w1c_merge(flags, clr_eff, set_vec);
  end

endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
  import cqs_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CMD_W   = 8,
  parameter int BND_RST = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CHAN_W = CMD_W - 1,
  localparam int NQ     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [CMD_W-1:0]  tbl_wdata,
  input  logic              bnd_we,
  input  logic [IDX_W-1:0]  bnd_wdata,
  input  logic              trig1,
  input  logic              trig2,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              conv_done,
  output logic              conv_req,
  output logic [IDX_W-1:0]  conv_idx,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_queue,
  output logic              q1_busy,
  output logic              q2_busy,
  output logic [STAT_W-1:0] status
);

  // boundary register
  logic [IDX_W-1:0] bnd_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      bnd_q <= IDX_W'(BND_RST);
    else if (bnd_we) bnd_q <= bnd_wdata;
  end

  // per-queue state
  logic [NQ-1:0]    q_trig, q_act, q_busy, q_ovr, q_adv, q_hold, q_fin, q_pause;
  logic [IDX_W-1:0] q_ptr   [NQ];
  logic [IDX_W-1:0] q_start [NQ];

  assign q_trig     = {trig2, trig1};
  assign q_start[0] = '0;
  assign q_start[1] = bnd_q;

  // sequencer state
  seq_e             seq_st;
  logic             cur_q2;
  logic [IDX_W-1:0] cur_idx;
  logic [CMD_W-1:0] cur_cmd;

  // fetch-side named events
  logic             pick_q2, fetch_go, bnd_hit, issue;
  logic [IDX_W-1:0] fetch_idx;
  logic [CMD_W-1:0] fetch_cmd;

  assign pick_q2   = !q_act[0] && q_act[1];
  assign fetch_idx = pick_q2 ? q_ptr[1] : q_ptr[0];
  assign fetch_go  = (seq_st == SQ_FETCH) && (|q_act);
  assign bnd_hit   = fetch_go && !pick_q2 && (fetch_idx == bnd_q);
  assign issue     = fetch_go && !bnd_hit;

  // completion-side named events
  logic conv_fin, fin_last, fin_pause;
  assign conv_fin  = (seq_st == SQ_WAIT) && conv_done;
  assign fin_last  = conv_fin && idx_is_last(int'(cur_idx), ENTRIES);
  assign fin_pause = conv_fin && cur_cmd[CMD_W-1];

  cqs_cmd_table #(.ENTRIES(ENTRIES), .CMD_W(CMD_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (fetch_idx),
    .rdata (fetch_cmd)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam bit IS_Q1 = (g == 0);
    logic mine;
    assign mine       = (cur_q2 == !IS_Q1);
    assign q_fin[g]   = (fin_last && mine) || (IS_Q1 && bnd_hit);
    assign q_pause[g] = fin_pause && mine;
    assign q_hold[g]  = fin_pause && !fin_last && mine;
    assign q_adv[g]   = conv_fin && !fin_last && mine;

    cqs_queue_ctl #(.IDX_W(IDX_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (q_trig[g]),
      .start_idx (q_start[g]),
      .advance   (q_adv[g]),
      .hold      (q_hold[g]),
      .finish    (q_fin[g]),
      .active    (q_act[g]),
      .busy      (q_busy[g]),
      .ptr       (q_ptr[g]),
      .overrun   (q_ovr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_st  <= SQ_FETCH;
      cur_q2  <= 1'b0;
      cur_idx <= '0;
      cur_cmd <= '0;
    end else begin
      case (seq_st)
        SQ_FETCH: if (issue) begin
          seq_st  <= SQ_WAIT;
          cur_q2  <= pick_q2;
          cur_idx <= fetch_idx;
          cur_cmd <= fetch_cmd;
        end
        SQ_WAIT: if (conv_done) seq_st <= SQ_FETCH;
        default: seq_st <= SQ_FETCH;
      endcase
    end
  end

  // status flags
  logic [STAT_W-1:0] flag_set;
  always_comb begin
    flag_set          = '0;
    flag_set[ST_CF1]  = q_fin[0];
    flag_set[ST_PF1]  = q_pause[0];
    flag_set[ST_TOR1] = q_ovr[0];
    flag_set[ST_CF2]  = q_fin[1];
    flag_set[ST_PF2]  = q_pause[1];
    flag_set[ST_TOR2] = q_ovr[1];
  end

  cqs_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .set_vec  (flag_set),
    .flags    (status)
  );

  assign conv_req   = (seq_st == SQ_WAIT);
  assign conv_idx   = cur_idx;
  assign conv_chan  = cur_cmd[CHAN_W-1:0];
  assign conv_queue = cur_q2;
  assign q1_busy    = q_busy[0];
  assign q2_busy    = q_busy[1];

endmodule

// File: rtl/cqs_checker.sv
module cqs_checker #(
  parameter int IDX_W  = 6,
  parameter int STAT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_req,
  input logic              conv_done,
  input logic [IDX_W-1:0]  conv_idx,
  input logic              conv_queue,
  input logic [IDX_W-1:0]  bnd_q,
  input logic              q1_run,
  input logic              trig1,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] hw_set
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_idx));

  // R2
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_req) |-> $past(conv_done));

  // R3
  bnd_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) && !conv_queue |-> conv_idx != $past(bnd_q));

  // R9
  q2_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) && conv_queue |-> !$past(q1_run));

  // R8
  tor1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig1 && q1_run |=> status[2]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((status & $past(hw_set)) == $past(hw_set)));

endmodule

bind cq_sequencer cqs_checker #(.IDX_W(IDX_W), .STAT_W(cqs_pkg::STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_req   (conv_req),
  .conv_done  (conv_done),
  .conv_idx   (conv_idx),
  .conv_queue (conv_queue),
  .bnd_q      (bnd_q),
  .q1_run     (q_act[0]),
  .trig1      (trig1),
  .status     (status),
  .hw_set     (flag_set)
);

// File: tb/cq_sequencer_tb.sv
module cq_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 64;
  localparam int LAST       = ENTRIES - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic       bnd_we = 1'b0;
  logic [5:0] bnd_wdata = '0;
  logic       trig1 = 1'b0, trig2 = 1'b0;
  logic       clr_we = 1'b0;
  logic [5:0] clr_mask = '0;
  logic       conv_done = 1'b0;
  logic       conv_req, conv_queue, q1_busy, q2_busy;
  logic [5:0] conv_idx, status;
  logic [6:0] conv_chan;

  cq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .bnd_we(bnd_we), .bnd_wdata(bnd_wdata),
    .trig1(trig1), .trig2(trig2), .clr_we(clr_we), .clr_mask(clr_mask),
    .conv_done(conv_done), .conv_req(conv_req), .conv_idx(conv_idx),
    .conv_chan(conv_chan), .conv_queue(conv_queue), .q1_busy(q1_busy),
    .q2_busy(q2_busy), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cycles = 0;
  logic [7:0] shadow [ENTRIES];
  int log_idx [512];
  int log_q   [512];
  int log_ch  [512];
  int log_n = 0;
  bit req_seen = 0;
  int wait_cnt = 0;

  // converter model and request log
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_done = 1'b0;
      req_seen  = 0;
    end else if (conv_done) begin
      conv_done = 1'b0;
    end else if (conv_req) begin
      if (!req_seen) begin
        if (log_n < 512) begin
          log_idx[log_n] = int'(conv_idx);
          log_q[log_n]   = int'(conv_queue);
          log_ch[log_n]  = int'(conv_chan);
          log_n++;
        end
        req_seen = 1;
        wait_cnt = int'($urandom_range(0, 2));
      end
      if (wait_cnt == 0) begin
        conv_done = 1'b1;
        req_seen  = 0;
      end else begin
        wait_cnt--;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog (R2): actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_tbl(input int a, input logic [7:0] d);
    shadow[a] = d;
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = d;
    tick();
    tbl_we = 1'b0;
  endtask

  task automatic wr_bnd(input int b);
    bnd_we = 1'b1; bnd_wdata = 6'(b);
    tick();
    bnd_we = 1'b0;
  endtask

  task automatic fire(input int q);
    if (q == 1) trig1 = 1'b1; else trig2 = 1'b1;
    tick();
    trig1 = 1'b0; trig2 = 1'b0;
  endtask

  task automatic clear(input logic [5:0] m);
    clr_we = 1'b1; clr_mask = m;
    tick();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    repeat (2) @(negedge clk);
    while ((q1_busy || q2_busy || conv_req) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(0, req, n, 0);
  endtask

  // expected: one contiguous run first..last for queue q
  function automatic int run_ok(input int q, input int first, input int last);
    if (log_n != last - first + 1) return 0;
    for (int k = 0; k < log_n; k++) begin
      if (log_idx[k] != first + k) return 0;
      if (log_q[k] != q) return 0;
      if (log_ch[k] != int'(shadow[first + k][6:0])) return 0;
    end
    return 1;
  endfunction

  function automatic int q1_end_for(input int bnd);
    return (bnd == 0) ? -1 : bnd - 1;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(status == 6'b0 && !conv_req && !q1_busy && !q2_busy, "R1 reset", int'(status), 0);

    for (int i = 0; i < ENTRIES; i++) wr_tbl(i, {1'b0, 7'($urandom)});

    // R3 basic queue 1 run to boundary 5
    wr_bnd(5); log_n = 0; fire(1); wait_idle("R3");
    check(run_ok(0, 0, 4) == 1, "R3 q1 sequence bnd=5", log_n, 5);
    check(status == 6'b000001, "R3 cf1", int'(status), 1);
    // R10 clear cf1
    clear(6'b000001); @(negedge clk);
    check(status == 6'b0, "R10 w1c cf1", int'(status), 0);

    // R6 R5 queue 2 from 60
    wr_bnd(60); log_n = 0; fire(2); wait_idle("R6");
    check(run_ok(1, 60, LAST) == 1, "R6 q2 sequence 60..63", log_n, 4);
    check(status == 6'b001000, "R5 cf2 after last entry", int'(status), 8);
    clear(6'h3f);

    // R3 boundary 0
    wr_bnd(0); log_n = 0; fire(1); wait_idle("R3");
    check(log_n == 0 && status == 6'b000001, "R3 empty queue 1", log_n, 0);
    clear(6'h3f);

    // R7 pause on entry 2
    wr_tbl(2, {1'b1, shadow[2][6:0]});
    wr_bnd(5); log_n = 0; fire(1);
    begin
      int n = 0;
      while (!status[1] && n < 1000) begin @(negedge clk); n++; end
    end
    repeat (4) @(negedge clk);
    check(run_ok(0, 0, 2) == 1, "R7 stop after pause entry", log_n, 3);
    check(status == 6'b000010 && q1_busy && !conv_req, "R7 pf1 and held", int'(status), 2);
    clear(6'b000010);
    log_n = 0; fire(1); wait_idle("R7");
    check(run_ok(0, 3, 4) == 1, "R7 resume at next entry", log_n, 2);
    check(status == 6'b000001, "R7 no overrun on resume", int'(status), 1);
    clear(6'h3f);
    wr_tbl(2, {1'b0, shadow[2][6:0]});

    // R8 R10 overrun and set-wins
    wr_bnd(40); log_n = 0; fire(1);
    while (log_n < 2) @(negedge clk);
    fire(1); @(negedge clk);
    check(status[2] == 1'b1, "R8 tor1 set", int'(status[2]), 1);
    trig1 = 1'b1; clr_we = 1'b1; clr_mask = 6'b000100;
    tick();
    trig1 = 1'b0; clr_we = 1'b0; clr_mask = '0;
    @(negedge clk);
    check(status[2] == 1'b1, "R10 set beats clear", int'(status[2]), 1);
    clear(6'b000100); @(negedge clk);
    check(status == 6'b0, "R10 clear tor1 only", int'(status), 0);
    wait_idle("R8");
    check(run_ok(0, 0, 39) == 1, "R8 queue not restarted", log_n, 40);
    clear(6'h3f);

    // R4 boundary rewrites during conversion of entry 7
    for (int t = 0; t < 3; t++) begin
      int nb;
      nb = (t == 0) ? 8 : (t == 1) ? 7 : 3;
      wr_bnd(20); log_n = 0; fire(1);
      begin
        int n = 0;
        while (!(conv_req && conv_idx == 6'd7) && n < 2000) begin @(negedge clk); n++; end
      end
      wr_bnd(nb);
      wait_idle("R4");
      if (t == 0) check(run_ok(0, 0, 7) == 1, "R4 bnd to next entry", log_n, 8);
      else        check(run_ok(0, 0, LAST) == 1, "R4 bnd at or below current", log_n, 64);
      clear(6'h3f);
    end

    // R9 priority with queue 2 suspended and resumed
    wr_bnd(10); log_n = 0; fire(2);
    while (log_n < 3) @(negedge clk);
    fire(1); wait_idle("R9");
    begin
      int n1 = 0, n2 = 0, first1 = -1, ok = 1;
      for (int k = 0; k < log_n; k++) begin
        if (log_q[k] == 0) begin
          if (first1 < 0) first1 = k;
          if (log_idx[k] != n1) ok = 0;
          n1++;
        end else begin
          if (log_idx[k] != 10 + n2) ok = 0;
          n2++;
        end
      end
      if (first1 < 3) ok = 0;
      for (int k = first1; k < first1 + 10 && k < log_n && k >= 0; k++)
        if (log_q[k] != 0) ok = 0;
      check(ok == 1 && n1 == 10 && n2 == 54, "R9 q1 preempts, q2 resumes", n2, 54);
    end
    check(status == 6'b001001, "R9 both complete", int'(status), 9);
    clear(6'h3f);

    // R2 R3 R6 random runs
    for (int it = 0; it < 30; it++) begin
      int b, q;
      b = int'($urandom_range(1, LAST));
      q = int'($urandom_range(1, 2));
      for (int j = 0; j < 4; j++) wr_tbl(int'($urandom_range(0, LAST)), {1'b0, 7'($urandom)});
      wr_bnd(b); log_n = 0; fire(q); wait_idle("R2");
      if (q == 1) begin
        check(run_ok(0, 0, q1_end_for(b)) == 1, "R2 R3 random q1 run", log_n, b);
        check(status == 6'b000001, "R3 random cf1", int'(status), 1);
      end else begin
        check(run_ok(1, b, LAST) == 1, "R2 R6 random q2 run", log_n, ENTRIES - b);
        check(status == 6'b001000, "R5 random cf2", int'(status), 8);
      end
      clear(6'h3f);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule